// File: doc/BRIEF.md
# Clock Select and Test-Bypass Divider

This block is the digital control and distribution logic for a motherboard clock generator. Two synthesized clocks arrive from outside: a CPU-rate clock and a 24 MHz clock. A reference clock also arrives, nominally 14.31818 MHz, and it doubles as the test clock. Two select pins choose the CPU frequency. The block turns that choice into a request code for the external synthesizer. It fans out four CPU clocks, six PCI clocks at half the CPU rate, a 24 MHz clock, a 12 MHz clock and two copies of the reference.

When both select pins are high, the block bypasses the synthesizers. Every output is then divided straight from the reference pin.

A single enable pin drives all clock outputs to high impedance when it is low. A settle timer runs in the reference domain and holds the `stable` flag low for a programmable number of reference cycles. The timer restarts after reset, after any change of the synchronized select pins, and after the synchronized enable rises. The block has no streaming data path; all pins are plain control, status or clock signals.

Top module: `clksel_bypass_div`

## Requirements
- R1: The pins {sel0, sel1} pass through two reference-clock flops and are then latched into `freq_req`. Bit 1 of `freq_req` is sel0 and bit 0 is sel1. The codes are 00 = 50 MHz, 01 = 60 MHz, 10 = 66 MHz and 11 = bypass (test) mode. `freq_req` changes only when the synchronized select differs from it.
- R2: While `oe` is low, every bit of `cpu_clk`, `pci_clk`, `ref_out`, `clk24_out` and `clk12_out` is high impedance, whatever the selects and the input clocks do.
- R3: In codes 00, 01 and 10, each `cpu_clk` bit follows `cpu_clk_in` and `clk24_out` follows `clk24_in`.
- R4: In codes 00, 01 and 10, each `pci_clk` bit toggles on every rising edge of the CPU clock (half rate), and `clk12_out` is `clk24_in` divided by two.
- R5: In code 11, measured against the reference input, `cpu_clk` runs at 1/2, `pci_clk` at 1/4, `clk24_out` at 1/4 and `clk12_out` at 1/8 of its rate.
- R6: When enabled, each `ref_out` bit carries the reference input in every mode.
- R7: After reset, `stable` stays low and rises SETTLE_CYCLES reference cycles later. It then holds high until a restart occurs.
- R8: A change in the synchronized select value, or a rise of the synchronized enable, drops `stable` to low and restarts the count.
- R9: All copies within a clock group are identical at all times.
- R10: `oe_status` shows `oe` after two reference-clock flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, and the test clock in bypass mode |
| cpu_clk_in | input | 1 | Synthesized CPU-rate clock |
| clk24_in | input | 1 | Synthesized 24 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel0 | input | 1 | Frequency select, high bit of the code |
| sel1 | input | 1 | Frequency select, low bit of the code |
| oe | input | 1 | Output enable; low forces all clock outputs to Z |
| freq_req | output | 2 | Frequency request to the synthesizer |
| stable | output | 1 | High once the settle count has completed |
| oe_status | output | 1 | Synchronized copy of oe |
| cpu_clk | output | N_CPU | CPU clock copies |
| pci_clk | output | N_PCI | PCI clock copies |
| ref_out | output | N_REF | Reference copies |
| clk24_out | output | 1 | 24 MHz clock out |
| clk12_out | output | 1 | 12 MHz clock out |

## Verification
Timing of each result, in reference cycles:
- `freq_req` and the divider clear settle three cycles after a select change.
- `oe_status` follows two cycles after `oe`.
- `stable` drops one cycle after the synchronized change.

The bench waits at least five reference cycles after each stimulus before it samples, on falling reference edges. High-impedance outputs are combinational, so they are checked 1 ns after `oe` falls. Frequency ratios only become valid once the dividers have cleared. For that reason each mode is measured over a 400-cycle edge-count window that opens ten cycles after the select change, with a tolerance of two edges for the window boundaries.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  typedef enum logic [1:0] {
    REQ_50M    = 2'b00,
    REQ_60M    = 2'b01,
    REQ_66M    = 2'b10,
    REQ_BYPASS = 2'b11
  } freq_req_e;
endpackage

// File: rtl/clksel_sync.sv
module clksel_sync
  import clksel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel0,
  input  logic      sel1,
  input  logic      oe,
  output freq_req_e freq_req,
  output logic      sel_restart,
  output logic      oe_rise,
  output logic      oe_sync
);
  logic [1:0] sel_m, sel_s;
  logic       oe_m, oe_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_m    <= '0;
      sel_s    <= '0;
      oe_m     <= 1'b0;
      oe_s     <= 1'b0;
      freq_req <= REQ_50M;
    end else begin
      sel_m <= {sel0, sel1};
      sel_s <= sel_m;
      oe_m  <= oe;
      oe_s  <= oe_m;
      if (sel_restart) freq_req <= freq_req_e'(sel_s);
    end
  end

  assign sel_restart = (sel_s != freq_req);
  // rise seen on the second stage input, so restart lands with oe_s going high
  assign oe_rise     = oe_m & ~oe_s;
  assign oe_sync     = oe_s;

  AST_REQ_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_req) |-> $past(sel_restart)); // R1
endmodule

// File: rtl/clksel_settle.sv
module clksel_settle #(
  parameter int SETTLE_CYCLES = 71591
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic stable
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      stable <= 1'b0;
    end else if (restart) begin
      cnt    <= '0;
      stable <= 1'b0;
    end else if (!stable) begin
      if (cnt == LAST) stable <= 1'b1;
      else             cnt    <= cnt + 1'b1;
    end
  end

  AST_RESTART_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !stable); // R8
  AST_STABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stable && !restart) |=> stable); // R7
endmodule

// File: rtl/clksel_divtree.sv
module clksel_divtree #(
  parameter int N_CPU = 4,
  parameter int N_PCI = 6,
  parameter int N_REF = 2
) (
  input  logic             ref_clk,
  input  logic             cpu_clk_in,
  input  logic             clk24_in,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic             clr,
  output logic [N_CPU-1:0] cpu_o,
  output logic [N_PCI-1:0] pci_o,
  output logic [N_REF-1:0] ref_o,
  output logic             c24_o,
  output logic             c12_o
);
  logic       clr_q, div_arst;
  logic [1:0] tcnt;
  logic       cpu_src, c24_src, pci_q, c12_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= clr;
  end

  assign div_arst = !rst_n || clr_q;

  // bypass prescaler: bit0 = ref/2, bit1 = ref/4
  always_ff @(posedge ref_clk or posedge div_arst) begin
    if (div_arst) tcnt <= '0;
    else          tcnt <= tcnt + 2'd1;
  end

  assign cpu_src = test_mode ? tcnt[0] : cpu_clk_in;
  assign c24_src = test_mode ? tcnt[1] : clk24_in;

  always_ff @(posedge cpu_src or posedge div_arst) begin
    if (div_arst) pci_q <= 1'b0;
    else          pci_q <= ~pci_q;
  end

  always_ff @(posedge c24_src or posedge div_arst) begin
    if (div_arst) c12_q <= 1'b0;
    else          c12_q <= ~c12_q;
  end

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    assign cpu_o[i] = cpu_src;
  end
  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    assign pci_o[i] = pci_q;
  end
  for (genvar i = 0; i < N_REF; i++) begin : g_ref
    assign ref_o[i] = ref_clk;
  end
  assign c24_o = c24_src;
  assign c12_o = c12_q;

  AST_BYPASS_COUNT_RUNS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (test_mode && !clr_q && !$past(clr_q)) |-> (tcnt != $past(tcnt))); // R5
endmodule

// File: rtl/clksel_bypass_div.sv
module clksel_bypass_div
  import clksel_pkg::*;
#(
  parameter int SETTLE_CYCLES = 71591,
  parameter int N_CPU         = 4,
  parameter int N_PCI         = 6,
  parameter int N_REF         = 2
) (
  input  logic             ref_clk,
  input  logic             cpu_clk_in,
  input  logic             clk24_in,
  input  logic             rst_n,
  input  logic             sel0,
  input  logic             sel1,
  input  logic             oe,
  output logic [1:0]       freq_req,
  output logic             stable,
  output logic             oe_status,
  output logic [N_CPU-1:0] cpu_clk,
  output logic [N_PCI-1:0] pci_clk,
  output logic [N_REF-1:0] ref_out,
  output logic             clk24_out,
  output logic             clk12_out
);
  freq_req_e        req;
  logic             sel_restart, oe_rise, restart, test_mode;
  logic [N_CPU-1:0] cpu_int;
  logic [N_PCI-1:0] pci_int;
  logic [N_REF-1:0] ref_int;
  logic             c24_int, c12_int;

  clksel_sync u_sync (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .sel0       (sel0),
    .sel1       (sel1),
    .oe         (oe),
    .freq_req   (req),
    .sel_restart(sel_restart),
    .oe_rise    (oe_rise),
    .oe_sync    (oe_status)
  );

  assign restart   = sel_restart | oe_rise;
  assign test_mode = (req == REQ_BYPASS);
  assign freq_req  = req;

  clksel_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .restart(restart),
    .stable (stable)
  );

  clksel_divtree #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_REF(N_REF)) u_div (
    .ref_clk   (ref_clk),
    .cpu_clk_in(cpu_clk_in),
    .clk24_in  (clk24_in),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .clr       (sel_restart),
    .cpu_o     (cpu_int),
    .pci_o     (pci_int),
    .ref_o     (ref_int),
    .c24_o     (c24_int),
    .c12_o     (c12_int)
  );

  assign cpu_clk   = oe ? cpu_int : {N_CPU{1'bz}};
  assign pci_clk   = oe ? pci_int : {N_PCI{1'bz}};
  assign ref_out   = oe ? ref_int : {N_REF{1'bz}};
  assign clk24_out = oe ? c24_int : 1'bz;
  assign clk12_out = oe ? c12_int : 1'bz;

  AST_OE_RISE_DROPS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(oe_status) |-> !stable); // R8
  AST_GROUP_IN_PHASE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ($countones(pci_int) == 0) || ($countones(pci_int) == N_PCI)); // R9
endmodule

// File: tb/clksel_bypass_div_bench.sv
module clksel_bypass_div_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 20;
  localparam int NC = 4, NP = 6, NR = 2;
  localparam int WIN = 400;

  logic ref_clk = 0, cpu_in = 0, c24_in = 0;
  logic rst_n = 0, sel0 = 0, sel1 = 0, oe = 0;
  logic [1:0] freq_req;
  logic stable, oe_status;
  wire [NC-1:0] cpu_clk;
  wire [NP-1:0] pci_clk;
  wire [NR-1:0] ref_out;
  wire clk24_out, clk12_out;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;
  always #2 cpu_in = ~cpu_in;
  always #7 c24_in = ~c24_in;

  clksel_bypass_div #(.SETTLE_CYCLES(SETTLE), .N_CPU(NC), .N_PCI(NP), .N_REF(NR))
  u_clksel_bypass_div (
    .ref_clk(ref_clk), .cpu_clk_in(cpu_in), .clk24_in(c24_in), .rst_n(rst_n),
    .sel0(sel0), .sel1(sel1), .oe(oe), .freq_req(freq_req), .stable(stable),
    .oe_status(oe_status), .cpu_clk(cpu_clk), .pci_clk(pci_clk), .ref_out(ref_out),
    .clk24_out(clk24_out), .clk12_out(clk12_out)
  );

  // free-running edge counters; windows use differences
  int n_ref = 0, n_cpu = 0, n_24 = 0, e_c24 = 0, e_c12 = 0;
  int e_cpu [NC];
  int e_pci [NP];
  int e_ref [NR];
  always @(posedge ref_clk) n_ref++;
  always @(posedge cpu_in)  n_cpu++;
  always @(posedge c24_in)  n_24++;
  always @(posedge clk24_out) if (oe) e_c24++;
  always @(posedge clk12_out) if (oe) e_c12++;
  for (genvar i = 0; i < NC; i++) begin : g_ccnt
    initial e_cpu[i] = 0;
    always @(posedge cpu_clk[i]) if (oe) e_cpu[i]++;
  end
  for (genvar i = 0; i < NP; i++) begin : g_pcnt
    initial e_pci[i] = 0;
    always @(posedge pci_clk[i]) if (oe) e_pci[i]++;
  end
  for (genvar i = 0; i < NR; i++) begin : g_rcnt
    initial e_ref[i] = 0;
    always @(posedge ref_out[i]) if (oe) e_ref[i]++;
  end

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic near(input string req, input int got, input int exp);
    int d;
    d = got - exp;
    chk(d <= 2 && d >= -2, req, got, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic run_mode(input logic s0, input logic s1);
    int r0, c0, t0, a24, a12;
    int ac [NC];
    int ap [NP];
    int ar [NR];
    int dr, dc, dt;
    sel0 = s0; sel1 = s1;
    cyc(10);
    chk(freq_req == {s0, s1}, "R1 freq_req", freq_req, {s0, s1});
    r0 = n_ref; c0 = n_cpu; t0 = n_24; a24 = e_c24; a12 = e_c12;
    for (int i = 0; i < NC; i++) ac[i] = e_cpu[i];
    for (int i = 0; i < NP; i++) ap[i] = e_pci[i];
    for (int i = 0; i < NR; i++) ar[i] = e_ref[i];
    for (int k = 0; k < WIN; k++) begin
      @(negedge ref_clk);
      checks++;
      if (!(cpu_clk == {NC{cpu_clk[0]}} && pci_clk == {NP{pci_clk[0]}})) begin
        fails++;
        $display("FAIL R9 group mismatch got cpu=%b pci=%b exp all-equal", cpu_clk, pci_clk);
      end
    end
    dr = n_ref - r0; dc = n_cpu - c0; dt = n_24 - t0;
    for (int i = 0; i < NR; i++) near("R6 ref copy", e_ref[i] - ar[i], dr);
    if (s0 && s1) begin
      for (int i = 0; i < NC; i++) near("R5 cpu ref/2", e_cpu[i] - ac[i], dr / 2);
      for (int i = 0; i < NP; i++) near("R5 pci ref/4", e_pci[i] - ap[i], dr / 4);
      near("R5 c24 ref/4", e_c24 - a24, dr / 4);
      near("R5 c12 ref/8", e_c12 - a12, dr / 8);
    end else begin
      for (int i = 0; i < NC; i++) near("R3 cpu follow", e_cpu[i] - ac[i], dc);
      near("R3 c24 follow", e_c24 - a24, dt);
      for (int i = 0; i < NP; i++) near("R4 pci half", e_pci[i] - ap[i], dc / 2);
      near("R4 c12 half", e_c12 - a12, dt / 2);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk(stable == 0, "R7 reset stable", stable, 0);
    chk(freq_req == 2'b00, "R1 reset code", freq_req, 0);
    #1;
    chk(cpu_clk === {NC{1'bz}} && pci_clk === {NP{1'bz}} && ref_out === {NR{1'bz}}
        && clk24_out === 1'bz && clk12_out === 1'bz, "R2 hiZ at reset", 0, 0);
    rst_n = 1;
    cyc(SETTLE - 5);
    chk(stable == 0, "R7 still counting", stable, 0);
    cyc(10);
    chk(stable == 1, "R7 settled", stable, 1);
    chk(oe_status == 0, "R10 oe low", oe_status, 0);
    oe = 1;
    cyc(1);
    chk(oe_status == 0, "R10 oe lag", oe_status, 0);
    cyc(4);
    chk(oe_status == 1, "R10 oe synced", oe_status, 1);
    chk(stable == 0, "R8 oe rise restart", stable, 0);
    cyc(SETTLE + 5);
    chk(stable == 1, "R7 resettled", stable, 1);
    for (int m = 0; m < 4; m++) begin
      run_mode(m[1], m[0]);
      chk(stable == 1, "R7 stable after mode", stable, 1);
    end
    sel0 = 0; sel1 = 1;
    cyc(5);
    chk(stable == 0, "R8 select change restart", stable, 0);
    cyc(SETTLE + 5);
    chk(stable == 1, "R7 stable again", stable, 1);
    oe = 0;
    #1;
    for (int k = 0; k < 6; k++) begin
      chk(cpu_clk === {NC{1'bz}} && pci_clk === {NP{1'bz}} && ref_out === {NR{1'bz}}
          && clk24_out === 1'bz && clk12_out === 1'bz, "R2 hiZ disabled", 0, 0);
      sel0 = k[0]; sel1 = k[1];
      cyc(3); #1;
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule